// File: doc/BRIEF.md
# PHY Header Builder with Serial CRC8

This block assembles a 32-bit physical-layer header from a handful of field inputs, protects it with an 8-bit CRC, and sends the finished header out one bit per clock, least significant bit first. A single-cycle load strobe captures the fields. The CRC is worked out on the fly as the leading field bits leave the block. The CRC bits then take their place in the bit stream straight after those field bits, so no second pass over the header is needed.

The fields are a three-bit rate code, a three-bit pilot spacing code, a two-bit sync code, a burst flag for the following packet, a scrambler seed bit and an eight-bit payload length in octets. When the rate-indicator mode input is high, the rate is carried by other means. The rate field is then sent as zero, because the far end does not read it. The output stream feeds whatever spreading stage follows. Each bit is qualified by a valid flag, and a done flag marks the end of the header.

Top module: `phy_hdr_builder`

## Requirements
- R1: After reset, bit_valid_o and done_o are both low and stay low until a load is accepted.
- R2: Header bit positions: rate code in bits 2:0, pilot code in 5:3, sync code in 7:6, burst flag in bit 8, scrambler seed in bit 11, payload length in 19:12 (bit 12 is the length LSB). Bits 9, 10 and 28 to 31 are always zero.
- R3: The rate code is copied unchanged into bits 2:0 for every value, from 000 up to the reserved codes 100 to 111. When ri_mode_i is high at load, bits 2:0 are sent as 000 whatever rate_i holds.
- R4: Bits 27:20 hold a CRC8 with generator x^8+x^2+x+1. It is computed over header bits 0 to 19 in transmission order by a shift register r0..r7: feedback = input XOR r7, r0 takes the feedback, r1 and r2 also take the feedback XORed into their shifted value, and the rest shift plainly. Register bit rk is sent as header bit 20+k, so r0 goes first.
- R5: A load accepted on one clock edge makes bit_valid_o high for exactly the next 32 cycles, carrying header bits 0 through 31 in that order.
- R6: done_o is high for exactly one cycle, the cycle right after the last header bit, and bit_valid_o is low in that cycle.
- R7: A load strobe while a header is still being sent is ignored. The header in progress is unchanged and no extra header follows.
- R8: The CRC register is cleared for every header, so a header loaded in the done cycle carries a CRC that depends only on its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start strobe; samples all field inputs |
| ri_mode_i | input | 1 | Rate indicated elsewhere; forces rate field to zero |
| rate_i | input | 3 | Rate code |
| pilot_i | input | 3 | Pilot spacing code |
| sync_i | input | 2 | Sync code (00 none, 10 frame sync) |
| burst_i | input | 1 | Next packet is part of a burst |
| seed_i | input | 1 | Scrambler seed selector |
| psdu_len_i | input | 8 | Payload length in octets |
| bit_o | output | 1 | Serial header bit |
| bit_valid_o | output | 1 | bit_o carries a header bit |
| done_o | output | 1 | One-cycle pulse after the last header bit |

## Verification
The header stream is tried with all-zero fields, which must give an all-zero CRC. It is also tried with single isolated field bits, which show whether each field lands at its own position, and with dense patterns that mix every field, to check the CRC feedback taps. Every rate code is sent, including the reserved ones, and the same non-zero rate is sent with rate-indicator mode on and off, which shows whether the override takes effect. A load strobe in the middle of a header shows that a second strobe is ignored. A load in the done cycle tells a CRC that is cleared per header apart from one that carries over from the last header.

// File: rtl/phdr_pkg.sv
package phdr_pkg;
    localparam int HDR_W    = 32;
    localparam int CRC_W    = 8;
    localparam int CRC_POS  = 20;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    localparam int RATE_LSB  = 0;
    localparam int PILOT_LSB = 3;
    localparam int SYNC_LSB  = 6;
    localparam int BURST_BIT = 8;
    localparam int SEED_BIT  = 11;
    localparam int LEN_LSB   = 12;

    typedef struct packed {
        logic       ri_mode;
        logic [2:0] rate;
        logic [2:0] pilot;
        logic [1:0] sync;
        logic       burst;
        logic       seed;
        logic [7:0] len;
    } hdr_fields_t;
endpackage

// File: rtl/phdr_field_pack.sv
module phdr_field_pack
    import phdr_pkg::*;
(
    input  hdr_fields_t      fields_i,
    output logic [HDR_W-1:0] word_o
);
    always_comb begin
        word_o = '0;
        word_o[RATE_LSB  +: 3] = fields_i.ri_mode ? 3'b000 : fields_i.rate;
        word_o[PILOT_LSB +: 3] = fields_i.pilot;
        word_o[SYNC_LSB  +: 2] = fields_i.sync;
        word_o[BURST_BIT]      = fields_i.burst;
        word_o[SEED_BIT]       = fields_i.seed;
        word_o[LEN_LSB   +: 8] = fields_i.len;
    end
endmodule

// File: rtl/phdr_crc8.sv
module phdr_crc8
    import phdr_pkg::*;
#(
    parameter int                W    = CRC_W,
    parameter logic [W-1:0]      POLY = CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         din_i,
    output logic [W-1:0] crc_o
);
    typedef struct packed {
        logic [W-1:0] rem;
    } crc_state_t;

    crc_state_t st_d, st_q;
    logic       fb;
    logic [W-1:0] stepped;

    assign fb = din_i ^ st_q.rem[W-1];

    for (genvar k = 0; k < W; k++) begin : g_tap
        if (k == 0) begin : g_first
            assign stepped[k] = fb;
        end else begin : g_rest
            assign stepped[k] = st_q.rem[k-1] ^ (POLY[k] & fb);
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.rem = '0;
        end else if (en_i) begin
            st_d.rem = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o = st_q.rem;

    assert_crc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (crc_o == '0));

    assert_crc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(crc_o));
endmodule

// File: rtl/phdr_serializer.sv
module phdr_serializer
    import phdr_pkg::*;
#(
    parameter int N    = HDR_W,
    parameter int CW   = CRC_W,
    parameter int CPOS = CRC_POS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [N-1:0]         word_i,
    input  logic [CW-1:0]        crc_i,
    output logic                 accept_o,
    output logic                 crc_clr_o,
    output logic                 crc_en_o,
    output logic                 crc_din_o,
    output logic                 bit_o,
    output logic                 valid_o,
    output logic                 done_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int CNT_W  = $clog2(N);
    localparam int CIDX_W = $clog2(CW);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(N - 1);
    localparam logic [CNT_W-1:0] CSTART = CNT_W'(CPOS);
    localparam logic [CNT_W-1:0] CEND   = CNT_W'(CPOS + CW);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [N-1:0]     word;
    } ser_state_t;

    ser_state_t st_d, st_q;
    logic             in_crc;
    logic [CNT_W-1:0] coff;

    assign accept_o = load_i && !st_q.busy;
    assign in_crc   = (st_q.cnt >= CSTART) && (st_q.cnt < CEND);
    assign coff     = st_q.cnt - CSTART;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (load_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.word = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_clr_o = accept_o;
    assign crc_en_o  = st_q.busy && (st_q.cnt < CSTART);
    assign crc_din_o = st_q.word[st_q.cnt];
    assign bit_o     = st_q.busy && (in_crc ? crc_i[coff[CIDX_W-1:0]] : st_q.word[st_q.cnt]);
    assign valid_o   = st_q.busy;
    assign done_o    = st_q.done;
    assign idx_o     = st_q.cnt;

    assert_start_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !valid_o && !done_o) |=> (valid_o && idx_o == '0));

    assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o != LAST) |=> (valid_o && idx_o == $past(idx_o) + 1'b1));

    assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o != LAST) |=> $stable(st_q.word));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o == LAST) |=> (done_o && !valid_o));
endmodule

// File: rtl/phy_hdr_builder.sv
module phy_hdr_builder
    import phdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       ri_mode_i,
    input  logic [2:0] rate_i,
    input  logic [2:0] pilot_i,
    input  logic [1:0] sync_i,
    input  logic       burst_i,
    input  logic       seed_i,
    input  logic [7:0] psdu_len_i,
    output logic       bit_o,
    output logic       bit_valid_o,
    output logic       done_o
);
    localparam int CNT_W = $clog2(HDR_W);

    typedef struct packed {
        logic ri;
    } top_state_t;

    hdr_fields_t      fields;
    logic [HDR_W-1:0] word;
    logic [CRC_W-1:0] crc;
    logic             accept, crc_clr, crc_en, crc_din;
    logic [CNT_W-1:0] idx;
    top_state_t       st_d, st_q;

    always_comb begin
        fields.ri_mode = ri_mode_i;
        fields.rate    = rate_i;
        fields.pilot   = pilot_i;
        fields.sync    = sync_i;
        fields.burst   = burst_i;
        fields.seed    = seed_i;
        fields.len     = psdu_len_i;
    end

    phdr_field_pack u_pack (
        .fields_i (fields),
        .word_o   (word)
    );

    phdr_crc8 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr),
        .en_i  (crc_en),
        .din_i (crc_din),
        .crc_o (crc)
    );

    phdr_serializer #(.N(HDR_W), .CW(CRC_W), .CPOS(CRC_POS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .word_i    (word),
        .crc_i     (crc),
        .accept_o  (accept),
        .crc_clr_o (crc_clr),
        .crc_en_o  (crc_en),
        .crc_din_o (crc_din),
        .bit_o     (bit_o),
        .valid_o   (bit_valid_o),
        .done_o    (done_o),
        .idx_o     (idx)
    );

    always_comb begin
        st_d = st_q;
        if (accept) st_d.ri = ri_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_ri_rate_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && st_q.ri && idx < CNT_W'(3)) |-> !bit_o);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && (idx == CNT_W'(9) || idx == CNT_W'(10) ||
                         idx >= CNT_W'(CRC_POS + CRC_W))) |-> !bit_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid_o |-> !bit_o);
endmodule

// File: tb/phy_hdr_builder_tb.sv
module phy_hdr_builder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0, ri_mode_i = 1'b0, burst_i = 1'b0, seed_i = 1'b0;
    logic [2:0] rate_i = '0, pilot_i = '0;
    logic [1:0] sync_i = '0;
    logic [7:0] psdu_len_i = '0;
    logic       bit_o, bit_valid_o, done_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    phy_hdr_builder dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .ri_mode_i(ri_mode_i),
        .rate_i(rate_i), .pilot_i(pilot_i), .sync_i(sync_i), .burst_i(burst_i),
        .seed_i(seed_i), .psdu_len_i(psdu_len_i),
        .bit_o(bit_o), .bit_valid_o(bit_valid_o), .done_o(done_o)
    );

    // stimulus vector: {ri, rate, pilot, sync, burst, seed, len}
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 3'b000, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00},
        {1'b0, 3'b001, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00},
        {1'b0, 3'b000, 3'b000, 2'b00, 1'b1, 1'b0, 8'h00},
        {1'b0, 3'b000, 3'b000, 2'b00, 1'b0, 1'b0, 8'h80},
        {1'b0, 3'b011, 3'b010, 2'b10, 1'b1, 1'b1, 8'hA5},
        {1'b0, 3'b111, 3'b111, 2'b11, 1'b1, 1'b1, 8'hFF},
        {1'b1, 3'b011, 3'b011, 2'b10, 1'b0, 1'b1, 8'h3C},
        {1'b0, 3'b101, 3'b110, 2'b01, 1'b0, 1'b0, 8'h01}
    };

    function automatic logic [31:0] model(input logic [18:0] v);
        logic [31:0] h;
        logic [7:0]  c;
        logic        fb;
        h = '0;
        h[2:0]   = v[18] ? 3'b000 : v[17:15];
        h[5:3]   = v[14:12];
        h[7:6]   = v[11:10];
        h[8]     = v[9];
        h[11]    = v[8];
        h[19:12] = v[7:0];
        c = '0;
        for (int i = 0; i < 20; i++) begin
            fb = h[i] ^ c[7];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        h[27:20] = c;
        return h;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [18:0] v);
        {ri_mode_i, rate_i, pilot_i, sync_i, burst_i, seed_i, psdu_len_i} = v;
    endtask

    // Called at a negedge; sends one header and returns at the done cycle.
    task automatic run_frame(input logic [18:0] v, input string req,
                             input bit mid_load, input logic [18:0] v2);
        logic [31:0] got;
        int          vcnt;
        apply(v);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        got = '0;
        vcnt = 0;
        for (int i = 0; i < 32; i++) begin
            if (bit_valid_o) vcnt++;
            got[i] = bit_o;
            if (mid_load && i == 10) begin
                apply(v2);
                load_i = 1'b1;
            end else begin
                load_i = 1'b0;
            end
            @(negedge clk);
        end
        load_i = 1'b0;
        check(got == model(v), req, "header", got, model(v));
        check(vcnt == 32, "R5", "valid cycles", 32'(vcnt), 32'd32);
        check(done_o && !bit_valid_o, "R6", "done cycle", {30'd0, done_o, bit_valid_o}, 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!bit_valid_o && !done_o, "R1", "in reset", {30'd0, bit_valid_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!bit_valid_o && !done_o, "R1", "idle after reset", {30'd0, bit_valid_o, done_o}, 0);

        // R2/R4: table walk
        for (int n = 0; n < NV; n++) begin
            run_frame(VEC[n], "R2_R4", 1'b0, '0);
            @(negedge clk);
            check(!done_o && !bit_valid_o, "R6", "done one cycle", {30'd0, done_o, bit_valid_o}, 0);
        end

        // R3: every rate code, RI off, then RI on
        for (int r = 0; r < 8; r++) begin
            run_frame({1'b0, 3'(r), 3'b001, 2'b00, 1'b0, 1'b1, 8'h11}, "R3", 1'b0, '0);
            @(negedge clk);
        end
        run_frame({1'b1, 3'b110, 3'b001, 2'b00, 1'b0, 1'b1, 8'h11}, "R3_ri", 1'b0, '0);
        @(negedge clk);
        a = model({1'b1, 3'b110, 3'b001, 2'b00, 1'b0, 1'b1, 8'h11});
        b = model({1'b0, 3'b000, 3'b001, 2'b00, 1'b0, 1'b1, 8'h11});
        check(a == b, "R3", "ri equals zero rate", a, b);

        // R7: load during transmission ignored, no extra header
        run_frame({1'b0, 3'b010, 3'b100, 2'b10, 1'b1, 1'b0, 8'h5A}, "R7", 1'b1,
                  {1'b0, 3'b001, 3'b011, 2'b00, 1'b0, 1'b1, 8'hC3});
        repeat (4) begin
            @(negedge clk);
            check(!bit_valid_o, "R7", "no extra header", {31'd0, bit_valid_o}, 0);
        end

        // R8: back-to-back load in done cycle, fresh CRC
        run_frame({1'b0, 3'b111, 3'b111, 2'b11, 1'b1, 1'b1, 8'hFF}, "R8_first", 1'b0, '0);
        run_frame({1'b0, 3'b000, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00}, "R8", 1'b0, '0);
        run_frame({1'b0, 3'b001, 3'b010, 2'b10, 1'b0, 1'b1, 8'h42}, "R8", 1'b0, '0);
        @(negedge clk);
        check(!done_o && !bit_valid_o, "R1", "idle at end", {30'd0, done_o, bit_valid_o}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule